// File: doc/BRIEF.md
# Direct-Form Discrete Fourier Transform Engine

This block computes an N-point discrete Fourier transform by plain matrix multiplication. One complex multiply-accumulate is issued on every clock. Input samples sit in a local sample memory, and the cosine and sine coefficients sit in a local coefficient memory indexed by a twiddle index. Both memories are filled through one shared load port. After `start`, the engine walks every output bin and writes the finished bins into a result memory, which is read through a read port with a latency of one cycle.

The adder is pipelined, so a running sum cannot be read back on the next cycle. To keep one multiply-accumulate per cycle anyway, the running sum of the current bin is split over eight partial accumulators. Sample `j` lands in partial `j mod 8`. Once all samples of the bin are in, a reduction pass adds the other seven partials into partial zero. The value in partial zero, saturated to 32 bits, becomes the bin result.

The engine uses fixed-point arithmetic. Samples and coefficients are signed Q1.15, and each result is in Q2.30 units. The transform size must be a power of two and at least 8.

Top module: `dft_engine`

## Requirements
- R1: For bin `i` and sample `j`, the coefficient used is the one stored at coefficient address `(i*j) mod N`.
- R2: Bin `i` real part is the sum over `j` of `xr[j]*c[k] - xi[j]*s[k]`, and the imaginary part is the sum of `xr[j]*s[k] + xi[j]*c[k]`, with `k` as in R1. Here `c` is the real half and `s` is the imaginary half of a coefficient word. All products are kept at full precision.
- R3: The updates of one bin go to the partial accumulators in the order 0,1,...,7,0,... (sample index mod 8). The final bin value is the sum of all eight partials.
- R4: All partial accumulators are cleared before each bin. No earlier bin or earlier run affects a result.
- R5: Each result half is the exact sum clipped to the signed 32-bit range [-2^31, 2^31-1].
- R6: `done` is high for exactly one cycle. The first rising clock edge that samples `start` high in idle is edge 0. `done` is high in the cycle after edge N*(N+11).
- R7: `start` is ignored while `busy` is high, so a run is neither restarted nor lengthened by it.
- R8: After reset, `busy` and `done` are low.
- R9: A load with `ld_coef`=0 writes `{ld_re, ld_im}` to sample address `ld_addr`. With `ld_coef`=1 it writes the cosine (`ld_re`) and sine (`ld_im`) to coefficient address `ld_addr`. `rd_re`/`rd_im` show bin `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transform (taken only when idle) |
| busy | output | 1 | High from the cycle after start until done |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Load strobe |
| ld_coef | input | 1 | 0 = sample memory, 1 = coefficient memory |
| ld_addr | input | log2(N) | Load address |
| ld_re | input | 16 | Sample real part or cosine, Q1.15 |
| ld_im | input | 16 | Sample imaginary part or sine, Q1.15 |
| rd_addr | input | log2(N) | Result bin to read |
| rd_re | output | 32 | Real part of the bin, Q2.30 |
| rd_im | output | 32 | Imaginary part of the bin, Q2.30 |

## Verification
The bench drives several kinds of input: an impulse, a full-scale DC input, a real cosine and a complex tone. A wrong twiddle index or a swapped sign in the complex product would move energy into the wrong bins. The positive and negative full-scale DC cases test clipping: a design that wrapped would report a small or sign-flipped bin zero. The runs follow one another, so a partial that was not cleared would carry an old sum into the next result. A restart on a stray `start` would show up as a longer run.

// File: rtl/dft_pkg.sv
package dft_pkg;
    localparam int DATA_W = 16;
    localparam int OUT_W  = 32;
    localparam int LANES  = 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int PROD_W = 2 * DATA_W + 1;

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } cpx_t;

    typedef struct packed {
        logic signed [PROD_W-1:0] re;
        logic signed [PROD_W-1:0] im;
    } prod_t;

    typedef enum logic [2:0] {
        S_IDLE, S_CLEAR, S_MAC, S_REDUCE, S_WB, S_DONE
    } state_t;
endpackage

// File: rtl/dft_ram.sv
module dft_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/dft_mac_pipe.sv
module dft_mac_pipe
    import dft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_v,
    input  logic [LANE_W-1:0] in_lane,
    input  cpx_t              x,
    input  cpx_t              w,
    output logic              out_v,
    output logic [LANE_W-1:0] out_lane,
    output prod_t             p
);
    logic signed [2*DATA_W-1:0] m_rc, m_is, m_rs, m_ic;

    always_comb begin
        m_rc = x.re * w.re;
        m_is = x.im * w.im;
        m_rs = x.re * w.im;
        m_ic = x.im * w.re;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v    <= 1'b0;
            out_lane <= '0;
            p        <= '0;
        end else begin
            out_v    <= in_v;
            out_lane <= in_lane;
            p.re     <= PROD_W'(m_rc) - PROD_W'(m_is);
            p.im     <= PROD_W'(m_rs) + PROD_W'(m_ic);
        end
    end
endmodule

// File: rtl/dft_lane_acc.sv
module dft_lane_acc
    import dft_pkg::*;
#(
    parameter int ACC_W = 43
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    upd_v,
    input  logic [LANE_W-1:0]       upd_lane,
    input  prod_t                   p,
    input  logic                    red_en,
    input  logic [LANE_W-1:0]       red_sel,
    output logic signed [OUT_W-1:0] sat_re,
    output logic signed [OUT_W-1:0] sat_im
);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    logic signed [ACC_W-1:0] lane_re [LANES];
    logic signed [ACC_W-1:0] lane_im [LANES];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int k = 0; k < LANES; k++) begin
                lane_re[k] <= '0;
                lane_im[k] <= '0;
            end
        end else if (upd_v) begin
            lane_re[upd_lane] <= lane_re[upd_lane] + ACC_W'(p.re);
            lane_im[upd_lane] <= lane_im[upd_lane] + ACC_W'(p.im);
        end else if (red_en) begin
            lane_re[0] <= lane_re[0] + lane_re[red_sel];
            lane_im[0] <= lane_im[0] + lane_im[red_sel];
        end
    end

    function automatic logic signed [OUT_W-1:0] clip(input logic signed [ACC_W-1:0] a);
        if (a > SAT_HI)      return OUT_W'(SAT_HI);
        else if (a < SAT_LO) return OUT_W'(SAT_LO);
        else                 return OUT_W'(a);
    endfunction

    always_comb begin
        sat_re = clip(lane_re[0]);
        sat_im = clip(lane_im[0]);
    end

    // R3: successive updates walk the lanes in order
    assert_lane_seq_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_v && $past(upd_v)) |-> (upd_lane == $past(upd_lane) + LANE_W'(1)));

    // R3: reduction never overlaps a live accumulation
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        upd_v |-> !(red_en || clr));

    // R4: clearing leaves empty partials behind
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (lane_re[0] == '0 && lane_im[LANES-1] == '0));
endmodule

// File: rtl/dft_engine.sv
module dft_engine
    import dft_pkg::*;
#(
    parameter int  N  = 1024,
    localparam int AW = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    input  logic                    ld_en,
    input  logic                    ld_coef,
    input  logic [AW-1:0]           ld_addr,
    input  logic signed [DATA_W-1:0] ld_re,
    input  logic signed [DATA_W-1:0] ld_im,
    input  logic [AW-1:0]           rd_addr,
    output logic signed [OUT_W-1:0] rd_re,
    output logic signed [OUT_W-1:0] rd_im
);
    localparam int ACC_W = PROD_W + AW;
    localparam int CW    = AW + 2;

    state_t            state;
    logic [AW-1:0]     bin, idx;
    logic [CW-1:0]     cnt;
    logic [LANE_W-1:0] rcnt;

    logic              v0, v1, v2;
    logic [LANE_W-1:0] lane1, lane2;
    cpx_t              x_rd, w_rd, ld_word;
    prod_t             prod;
    logic signed [OUT_W-1:0] sat_re, sat_im;
    logic [2*OUT_W-1:0]      res_q;

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            bin   <= '0;
            idx   <= '0;
            cnt   <= '0;
            rcnt  <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    bin   <= '0;
                    state <= S_CLEAR;
                end
                S_CLEAR: begin
                    cnt   <= '0;
                    idx   <= '0;
                    state <= S_MAC;
                end
                S_MAC: begin
                    cnt <= cnt + CW'(1);
                    if (cnt < CW'(N)) idx <= idx + bin;
                    if (cnt == CW'(N + 1)) begin
                        rcnt  <= LANE_W'(1);
                        state <= S_REDUCE;
                    end
                end
                S_REDUCE: begin
                    rcnt <= rcnt + LANE_W'(1);
                    if (rcnt == LANE_W'(LANES - 1)) state <= S_WB;
                end
                S_WB: begin
                    if (bin == AW'(N - 1)) state <= S_DONE;
                    else begin
                        bin   <= bin + AW'(1);
                        state <= S_CLEAR;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_DONE);
    assign v0   = (state == S_MAC) && (cnt < CW'(N));
    assign ld_word = '{re: ld_re, im: ld_im};

    // stage 1: memory read
    dft_ram #(.W(2*DATA_W), .DEPTH(N)) u_samples (
        .clk(clk), .we(ld_en && !ld_coef), .waddr(ld_addr), .wdata(ld_word),
        .raddr(cnt[AW-1:0]), .rdata(x_rd));

    dft_ram #(.W(2*DATA_W), .DEPTH(N)) u_coefs (
        .clk(clk), .we(ld_en && ld_coef), .waddr(ld_addr), .wdata(ld_word),
        .raddr(idx), .rdata(w_rd));

    always_ff @(posedge clk) begin
        if (rst) begin
            v1    <= 1'b0;
            lane1 <= '0;
        end else begin
            v1    <= v0;
            lane1 <= cnt[LANE_W-1:0];
        end
    end

    // stage 2: multiply
    dft_mac_pipe u_mac (
        .clk(clk), .rst(rst), .in_v(v1), .in_lane(lane1), .x(x_rd), .w(w_rd),
        .out_v(v2), .out_lane(lane2), .p(prod));

    // stage 3: accumulate, reduce, saturate
    dft_lane_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .clr(state == S_CLEAR),
        .upd_v(v2), .upd_lane(lane2), .p(prod),
        .red_en(state == S_REDUCE), .red_sel(rcnt),
        .sat_re(sat_re), .sat_im(sat_im));

    dft_ram #(.W(2*OUT_W), .DEPTH(N)) u_results (
        .clk(clk), .we(state == S_WB), .waddr(bin), .wdata({sat_re, sat_im}),
        .raddr(rd_addr), .rdata(res_q));

    assign rd_re = res_q[2*OUT_W-1:OUT_W];
    assign rd_im = res_q[OUT_W-1:0];

    // R6: completion is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: the bin being worked on holds through accumulation and reduction
    assert_bin_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_MAC || state == S_REDUCE) |=> $stable(bin));

    // R7: a run only begins from a sampled start
    assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R4: a result is written only after the reduction pass
    assert_wb_after_reduce_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_WB) |-> ($past(state) == S_REDUCE));
endmodule

// File: tb/dft_engine_test.sv
module dft_engine_test;
    localparam int N   = 16;
    localparam int AW  = $clog2(N);
    localparam int NC  = 5;
    localparam real PI = 3.14159265358979;

    // kind: 0 impulse, 1 DC, 2 real cosine, 3 complex tone; amp; frequency
    localparam int CASES [NC][3] = '{
        '{0, 16384, 0},
        '{1, 32767, 0},
        '{2, 2000, 3},
        '{3, 3000, 5},
        '{1, -32768, 0}
    };

    logic clk = 1'b0;
    logic rst, start, busy, done, ld_en, ld_coef;
    logic [AW-1:0] ld_addr, rd_addr;
    logic signed [15:0] ld_re, ld_im;
    logic signed [31:0] rd_re, rd_im;

    int checks = 0;
    int fails  = 0;
    int xr [N], xi [N], cr [N], sr [N];

    always #5 clk = ~clk;

    dft_engine #(.N(N)) uut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .ld_en(ld_en), .ld_coef(ld_coef), .ld_addr(ld_addr),
        .ld_re(ld_re), .ld_im(ld_im),
        .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im));

    task automatic check(input string req, input longint act, input longint exp, input longint tol);
        longint d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clip32(input longint v);
        if (v > 64'sd2147483647) return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    task automatic load(input logic coef, input int a, input int re, input int im);
        @(negedge clk);
        ld_en = 1'b1; ld_coef = coef; ld_addr = AW'(a);
        ld_re = 16'(re); ld_im = 16'(im);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // run one transform; count cycles to done, poke start mid-run
    task automatic run(input string tag);
        int cyc;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (cyc == 50) start = 1'b1;
            if (cyc == 51) begin
                start = 1'b0;
                check({"R7 busy during run ", tag}, busy, 1, 0);
            end
            @(negedge clk);
            cyc++;
        end
        check({"R6/R7 cycles to done ", tag}, cyc, N * (N + 11), 0);
        @(negedge clk);
        check({"R6 done one cycle ", tag}, done, 0, 0);
        check({"R6 idle after done ", tag}, busy, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; ld_en = 1'b0; ld_coef = 1'b0;
        ld_addr = '0; ld_re = '0; ld_im = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 busy after reset", busy, 0, 0);
        check("R8 done after reset", done, 0, 0);

        // coefficient table: cos and negative sin, Q1.15 (R9 load path)
        for (int k = 0; k < N; k++) begin
            cr[k] = int'($rtoi($floor(32767.0 * $cos(2.0 * PI * k / N) + 0.5)));
            sr[k] = int'($rtoi($floor(-32767.0 * $sin(2.0 * PI * k / N) + 0.5)));
            load(1'b1, k, cr[k], sr[k]);
        end

        for (int c = 0; c < NC; c++) begin
            for (int j = 0; j < N; j++) begin
                case (CASES[c][0])
                    0: begin xr[j] = (j == 0) ? CASES[c][1] : 0; xi[j] = 0; end
                    1: begin xr[j] = CASES[c][1]; xi[j] = 0; end
                    2: begin
                        xr[j] = int'($rtoi($floor(CASES[c][1] * $cos(2.0 * PI * CASES[c][2] * j / N) + 0.5)));
                        xi[j] = 0;
                    end
                    default: begin
                        xr[j] = int'($rtoi($floor(CASES[c][1] * $cos(2.0 * PI * CASES[c][2] * j / N) + 0.5)));
                        xi[j] = int'($rtoi($floor(CASES[c][1] * $sin(2.0 * PI * CASES[c][2] * j / N) + 0.5)));
                    end
                endcase
                load(1'b0, j, xr[j], xi[j]);
            end
            run($sformatf("case %0d", c));
            for (int i = 0; i < N; i++) begin
                longint er, ei;
                er = 0; ei = 0;
                for (int j = 0; j < N; j++) begin
                    int k;
                    k = (i * j) % N;   // R1 twiddle index
                    er += longint'(xr[j]) * cr[k] - longint'(xi[j]) * sr[k];   // R2
                    ei += longint'(xr[j]) * sr[k] + longint'(xi[j]) * cr[k];
                end
                @(negedge clk); rd_addr = AW'(i);
                @(negedge clk);
                // R1 R2 R3 R4 R5 R9 all feed each bin value
                check($sformatf("R1/R2/R3/R4/R5 case %0d bin %0d re", c, i), rd_re, clip32(er), 1);
                check($sformatf("R1/R2/R3/R4/R5 case %0d bin %0d im", c, i), rd_im, clip32(ei), 1);
            end
        end

        // R5 explicit corner: full-scale DC clips at the negative rail (last case)
        @(negedge clk); rd_addr = '0;
        @(negedge clk);
        check("R5 negative rail bin 0", rd_re, -64'sd2147483648, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule